// File: doc/BRIEF.md
# Immediate-to-Memory Byte Store Encoder

This block turns a request for "store this 8-bit constant at the address held in general register N" into its machine-code byte string. A one-cycle start pulse captures a 3-bit base register number and the immediate. The block then emits the encoding one byte per cycle on a valid/ready stream and flags the final byte with last. It is meant to sit behind a code generator or a trace rebuilder that has already picked the operation and the register and only needs the bytes.

The encoding never requests a displacement. Two register numbers cannot be written in the plain register-indirect form, and the block handles both. Register 4 (the stack pointer) needs a scale/index/base byte. Register 5 (the frame pointer) needs the one-byte-displacement form with a zero displacement. A sequence is therefore 3 or 4 bytes long.

The controller has five states:
- IDLE waits for start. On start it captures the operands and moves to OPCODE.
- OPCODE emits the opcode byte.
- ADDR emits the addressing byte.
- EXTRA emits the inserted byte. It is used only for registers 4 and 5.
- IMM emits the immediate with last set.

Transitions out of a byte-emitting state happen only on a handshake:
- OPCODE goes to ADDR.
- ADDR goes to EXTRA for registers 4 and 5, and to IMM for all others.
- EXTRA goes to IMM.
- IMM goes back to IDLE.

Top module: `imm_store_encoder`

## Requirements
- R1: After reset, out_valid_o, out_last_o and busy_o are low. While busy_o is low, out_valid_o is low.
- R2: The first byte of every sequence is 0xC6. This is the opcode, with the register-field extension equal to 0.
- R3: For base registers 0, 1, 2, 3, 6 and 7, the sequence is 3 bytes: 0xC6, then an addressing byte equal to the register number (mod=00 in bits 7:6, reg=000 in bits 5:3, r/m=register in bits 2:0), then the immediate.
- R4: For base register 4, the sequence is 4 bytes: 0xC6, 0x04, 0x24, then the immediate. The value 0x24 encodes scale 0, index 4 (no index) and base 4.
- R5: For base register 5, the sequence is 4 bytes: 0xC6, 0x45, 0x00, then the immediate. The value 0x45 encodes mod=01 with r/m=5, and 0x00 is the displacement.
- R6: A byte is taken only in a cycle with out_valid_o and out_ready_i both high. out_last_o is high only on the immediate byte, which is always the final byte.
- R7: While out_valid_o is high and out_ready_i is low, the next cycle still shows out_valid_o high, with out_byte_o and out_last_o unchanged.
- R8: busy_o goes high in the cycle after an accepted start and falls after the last byte is taken. A start_i pulse while busy_o is high is ignored and adds no bytes to the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new encoding (taken only when idle) |
| base_i | input | 3 | Base register number |
| imm_i | input | 8 | Immediate value to store |
| busy_o | output | 1 | A sequence is in progress |
| out_valid_o | output | 1 | out_byte_o holds a byte |
| out_ready_i | input | 1 | Consumer accepts the byte |
| out_byte_o | output | 8 | Encoded byte |
| out_last_o | output | 1 | Final byte of the sequence |

## Verification
A controller in the wrong state shows up within one handshake as a misplaced byte. For example, a skipped EXTRA state makes the immediate appear one byte early with last set. An unwanted EXTRA state inserts a stray byte into a 3-byte sequence. A base register captured wrongly changes the addressing byte, which is the second byte out. A start that is not ignored while busy appends a whole extra sequence, so the stream ends with bytes nobody expected. Stalls from out_ready_i expose any byte or state that moves without a handshake.

// File: rtl/imm_store_enc_pkg.sv
package imm_store_enc_pkg;

    localparam int REG_W  = 3;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_MOV_IMM8   = 8'hC6;
    localparam logic [REG_W-1:0]  REG_STACK_PTR  = 3'd4;
    localparam logic [REG_W-1:0]  REG_FRAME_PTR  = 3'd5;
    localparam logic [1:0]        MOD_NO_DISP    = 2'b00;
    localparam logic [1:0]        MOD_DISP8      = 2'b01;
    localparam logic [2:0]        OPC_EXT        = 3'b000;
    localparam logic [2:0]        SIB_NO_INDEX   = 3'd4;
    localparam logic [1:0]        SIB_SCALE_1    = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_EXTRA,
        ST_IMM
    } enc_state_t;

endpackage

// File: rtl/addr_form_decode.sv
module addr_form_decode
    import imm_store_enc_pkg::*;
(
    input  logic [REG_W-1:0]  base_reg,
    output logic [BYTE_W-1:0] addr_byte,
    output logic              need_extra,
    output logic [BYTE_W-1:0] extra_byte
);

    always_comb begin
        addr_byte  = {MOD_NO_DISP, OPC_EXT, base_reg};
        need_extra = 1'b0;
        extra_byte = '0;
        if (base_reg == REG_STACK_PTR) begin
            // r/m=4 selects the scale/index/base form; the extra byte names no index
            need_extra = 1'b1;
            extra_byte = {SIB_SCALE_1, SIB_NO_INDEX, REG_STACK_PTR};
        end else if (base_reg == REG_FRAME_PTR) begin
            // mod=00,r/m=5 would mean absolute address: use a zero 8-bit displacement
            addr_byte  = {MOD_DISP8, OPC_EXT, base_reg};
            need_extra = 1'b1;
            extra_byte = '0;
        end
    end

endmodule

// File: rtl/enc_seq_fsm.sv
module enc_seq_fsm
    import imm_store_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  base_in,
    input  logic [BYTE_W-1:0] imm_in,
    input  logic              ready,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              need_extra,
    input  logic [BYTE_W-1:0] extra_byte,
    output logic [REG_W-1:0]  base_q,
    output logic              busy,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              last
);

    enc_state_t state_q, state_d;
    logic [BYTE_W-1:0] imm_q;
    logic              take;

    assign take = valid && ready;

    // state register and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            imm_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                base_q <= base_in;
                imm_q  <= imm_in;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_OPCODE;
            ST_OPCODE: if (take)  state_d = ST_ADDR;
            ST_ADDR:   if (take)  state_d = need_extra ? ST_EXTRA : ST_IMM;
            ST_EXTRA:  if (take)  state_d = ST_IMM;
            ST_IMM:    if (take)  state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        valid = 1'b1;
        last  = 1'b0;
        data  = '0;
        busy  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                valid = 1'b0;
                busy  = 1'b0;
            end
            ST_OPCODE: data = OPC_MOV_IMM8;
            ST_ADDR:   data = addr_byte;
            ST_EXTRA:  data = extra_byte;
            ST_IMM: begin
                data = imm_q;
                last = 1'b1;
            end
            default: begin
                valid = 1'b0;
                busy  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/imm_store_encoder.sv
module imm_store_encoder
    import imm_store_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_W-1:0]  base_i,
    input  logic [BYTE_W-1:0] imm_i,
    output logic              busy_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              out_last_o
);

    logic [REG_W-1:0]  base_q;
    logic [BYTE_W-1:0] addr_byte;
    logic [BYTE_W-1:0] extra_byte;
    logic              need_extra;

    addr_form_decode u_decode (
        .base_reg   (base_q),
        .addr_byte  (addr_byte),
        .need_extra (need_extra),
        .extra_byte (extra_byte)
    );

    enc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .base_in    (base_i),
        .imm_in     (imm_i),
        .ready      (out_ready_i),
        .addr_byte  (addr_byte),
        .need_extra (need_extra),
        .extra_byte (extra_byte),
        .base_q     (base_q),
        .busy       (busy_o),
        .valid      (out_valid_o),
        .data       (out_byte_o),
        .last       (out_last_o)
    );

endmodule

// File: rtl/imm_store_encoder_chk.sv
module imm_store_encoder_chk
    import imm_store_enc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [REG_W-1:0]  base_i,
    input logic [BYTE_W-1:0] imm_i,
    input logic              busy_o,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [BYTE_W-1:0] out_byte_o,
    input logic              out_last_o
);

    // R1: no byte offered while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !out_valid_o);

    // R2: a fresh sequence opens with the opcode
    a_r2_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> out_byte_o == OPC_MOV_IMM8);

    // R6: last only on an offered byte
    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    // R6: taking the last byte ends the sequence
    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i && out_last_o |=> !busy_o);

    // R7: stalled byte is held
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o) && $stable(out_last_o));

    // R8: an accepted start makes the block busy
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o);

endmodule

bind imm_store_encoder imm_store_encoder_chk chk_i (.*);

// File: tb/imm_store_encoder_tb_top.sv
module imm_store_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] base_i = '0;
    logic [7:0] imm_i = '0;
    logic       busy_o, out_valid_o, out_last_o;
    logic       out_ready_i = 1'b1;
    logic [7:0] out_byte_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ready_mode = 0;

    logic [8:0] exp_q[$];
    string      req_q[$];

    always #10 clk = ~clk;

    imm_store_encoder dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic last, input logic [7:0] b, input string req);
        exp_q.push_back({last, b});
        req_q.push_back(req);
    endtask

    // driver: build the expected bytes from the requirements and launch a request
    task automatic send(input logic [2:0] b, input logic [7:0] imm, input bit poke_busy);
        string r;
        while (busy_o || exp_q.size() != 0) @(negedge clk);
        r = (b == 3'd4) ? "R4" : (b == 3'd5) ? "R5" : "R3";
        push(1'b0, 8'hC6, "R2");
        if (b == 3'd4) begin
            push(1'b0, 8'h04, r);
            push(1'b0, 8'h24, r);
        end else if (b == 3'd5) begin
            push(1'b0, 8'h45, r);
            push(1'b0, 8'h00, r);
        end else begin
            push(1'b0, {5'b0, b}, r);
        end
        push(1'b1, imm, "R6");
        start_i = 1'b1;
        base_i  = b;
        imm_i   = imm;
        @(negedge clk);
        check(busy_o == 1'b1, "R8", busy_o, 1);
        if (poke_busy) begin
            base_i = ~b;
            imm_i  = ~imm;
        end else begin
            start_i = 1'b0;
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // ready pattern
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0: out_ready_i = 1'b1;
            1: out_ready_i = cyc[0];
            default: out_ready_i = (cyc % 3) != 0;
        endcase
    end

    // monitor: compare accepted bytes with the scoreboard; check stall hold
    logic       prev_stall = 1'b0;
    logic [8:0] prev_item = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(out_valid_o && {out_last_o, out_byte_o} == prev_item, "R7",
                      {out_valid_o, out_last_o, out_byte_o}, {1'b1, prev_item});
            if (out_valid_o && out_ready_i) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 extra byte", {out_last_o, out_byte_o}, 0);
                end else begin
                    logic [8:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check({out_last_o, out_byte_o} == e, r, {out_last_o, out_byte_o}, e);
                end
            end
            prev_stall = out_valid_o && !out_ready_i;
            prev_item  = {out_last_o, out_byte_o};
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid_o && !busy_o && !out_last_o, "R1", {out_valid_o, busy_o, out_last_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid_o && !busy_o, "R1", {out_valid_o, busy_o}, 0);
        for (int m = 0; m < 3; m++) begin
            ready_mode = m;
            for (int r = 0; r < 8; r++)
                send(3'(r), 8'(8'h12 + r * 8'h11 + m), (r % 3) == 1);
        end
        ready_mode = 0;
        send(3'd5, 8'h00, 1'b1);
        send(3'd4, 8'hFF, 1'b0);
        while (busy_o || exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0 && !busy_o && !out_valid_o, "R8", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule